// File: doc/BRIEF.md
# Load Sentinel Trap Detector

This block sits on the load-return path of a processor core. It watches each returned load word and compares it with a sentinel value that system software programs. The memory system marks a cache line as invalid by filling it with the sentinel pattern, so a load that returns that pattern has read stale data. When checking is enabled and the returned bytes equal the sentinel, the load is not completed. In the same cycle the block raises a coherence trap instead, and it records the faulting address and hardware thread so that a software handler can resolve the miss.

A load that does not match passes straight through to the writeback port in the same cycle, with no added latency. The trap status is held until software acknowledges it. While it is held, a second matching load raises no new trap and is flagged for replay. A legitimate program value that happens to equal the sentinel also traps. Software tells such a false miss apart from a real one.

Top module: `ld_sentinel_trap`

## Requirements
- R1: After reset the sentinel is zero, checking is disabled, `trap_pending` is 0 and `trap_addr` and `trap_tid` are zero.
- R2: A configuration write with `cfg_wr_addr` = 0 loads the whole sentinel. A write with `cfg_wr_addr` = 1 loads the enable from bit 0 of `cfg_wr_data`. A write takes effect from the clock edge that accepts it, so a load in the same cycle still sees the old value.
- R3: With checking disabled, every valid load is delivered on `wb_valid` and no trap or replay is raised, whatever the data.
- R4: For a 64-bit load (`ld_size` = 3) the trap condition is that the full returned word equals the sentinel.
- R5: `ld_size` encodes 1, 2, 4 or 8 bytes as 0, 1, 2, 3. Narrow data is right-aligned in `ld_data`. With n bytes, the lane offset is `ld_addr[2:0]` with its low log2(n) bits cleared. Returned byte i is compared with sentinel byte (offset + i), where byte k is bits 8k+7..8k. Data bytes at or above n are ignored.
- R6: A load that meets the trap condition while no trap is pending asserts `trap_fire` in its own cycle, and `wb_valid` stays low in that cycle.
- R7: A load that does not meet the trap condition asserts `wb_valid` in the same cycle, with `wb_data` and `wb_tid` equal to `ld_data` and `ld_tid`. Neither `trap_fire` nor `replay` is raised.
- R8: On the edge after `trap_fire`, `trap_pending` is 1 and `trap_addr` and `trap_tid` hold that load's address and thread.
- R9: While `trap_pending` is 1, a load that meets the trap condition raises `replay` instead of `trap_fire` and is not delivered. The recorded address and thread stay unchanged.
- R10: `trap_ack` clears `trap_pending` on the next edge. After that, a matching load traps again and records new status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 1 | 0 = sentinel, 1 = control (bit 0 enable) |
| cfg_wr_data | input | DATA_W | Configuration write data |
| ld_valid | input | 1 | Load response valid |
| ld_data | input | DATA_W | Returned load data, right-aligned |
| ld_addr | input | ADDR_W | Load virtual address |
| ld_tid | input | TID_W | Hardware thread of the load |
| ld_size | input | SIZE_W | log2 of the access size in bytes |
| wb_valid | output | 1 | Load completes to its destination |
| wb_data | output | DATA_W | Data delivered to writeback |
| wb_tid | output | TID_W | Thread of the delivered load |
| trap_fire | output | 1 | Coherence trap for the current load |
| replay | output | 1 | Matching load blocked by a pending trap |
| trap_pending | output | 1 | Trap status held for software |
| trap_addr | output | ADDR_W | Address of the trapping load |
| trap_tid | output | TID_W | Thread of the trapping load |
| trap_ack | input | 1 | Software acknowledge of the trap |

## Verification
The compare is swept over every access size, every aligned lane offset and unaligned low address bits. Each sweep point is tried with an exact sentinel image, then with one byte corrupted at each of the eight positions. Corrupting a byte inside the access must stop the trap, while corrupting a byte above it must not, so the sweep tells the lane rotation apart from the size masking. Separate patterns check the following: a sentinel written in the same cycle as the load it would match, a match arriving while a trap is pending, an acknowledge given together with a match, and data that matches the reset sentinel of zero while checking is disabled.

// File: rtl/ldsn_pkg.sv
package ldsn_pkg;
   localparam logic CFG_SENTINEL = 1'b0;
   localparam logic CFG_CONTROL  = 1'b1;
   localparam int   CTRL_EN_BIT  = 0;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } ld_size_e;
endpackage

// File: rtl/ldsn_cfg_regs.sv
module ldsn_cfg_regs #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] sentinel_o,
   output logic              enable_o
);
   import ldsn_pkg::*;

   logic [DATA_W-1:0] sentinel_q;
   logic              enable_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sentinel_q <= '0;
         enable_q   <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == CFG_SENTINEL)
            sentinel_q <= wr_data;
         else
            enable_q   <= wr_data[CTRL_EN_BIT];
      end
   end

   assign sentinel_o = sentinel_q;
   assign enable_o   = enable_q;
endmodule

// File: rtl/ldsn_lane_align.sv
module ldsn_lane_align #(
   parameter int NBYTES = 8,
   parameter int OFF_W  = 3,
   parameter int SIZE_W = 2
) (
   input  logic [SIZE_W-1:0]   size_i,
   input  logic [OFF_W-1:0]    addr_lo_i,
   input  logic [8*NBYTES-1:0] sentinel_i,
   output logic [8*NBYTES-1:0] sent_aligned_o,
   output logic [NBYTES-1:0]   byte_mask_o
);
   localparam int LOG2_NB = $clog2(NBYTES);

   logic [SIZE_W-1:0] nb_log;
   logic [OFF_W-1:0]  low_bits;
   logic [OFF_W-1:0]  lane_off;
   logic [OFF_W:0]    nbytes;

   always_comb begin
      nb_log   = (int'(size_i) > LOG2_NB) ? SIZE_W'(LOG2_NB) : size_i;
      nbytes   = (OFF_W+1)'(1) << nb_log;
      low_bits = OFF_W'(nbytes - (OFF_W+1)'(1));
      lane_off = addr_lo_i & ~low_bits;
   end

   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      logic [OFF_W-1:0] src_idx;
      assign src_idx = lane_off + OFF_W'(i);
      assign sent_aligned_o[8*i +: 8] = sentinel_i[8*src_idx +: 8];
      assign byte_mask_o[i] = ((OFF_W+1)'(i) < nbytes);
   end
endmodule

// File: rtl/ldsn_compare.sv
module ldsn_compare #(
   parameter int NBYTES = 8
) (
   input  logic [8*NBYTES-1:0] data_i,
   input  logic [8*NBYTES-1:0] ref_i,
   input  logic [NBYTES-1:0]   mask_i,
   output logic                match_o
);
   logic [NBYTES-1:0] byte_ok;

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      assign byte_ok[i] = !mask_i[i] || (data_i[8*i +: 8] == ref_i[8*i +: 8]);
   end

   assign match_o = &byte_ok;
endmodule

// File: rtl/ldsn_trap_ctl.sv
module ldsn_trap_ctl #(
   parameter int ADDR_W = 48,
   parameter int TID_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [TID_W-1:0]  ld_tid_i,
   input  logic              hit_i,
   input  logic              ack_i,
   output logic              wb_valid_o,
   output logic              trap_fire_o,
   output logic              replay_o,
   output logic              pending_o,
   output logic [ADDR_W-1:0] trap_addr_o,
   output logic [TID_W-1:0]  trap_tid_o
);
   logic              pending_q;
   logic [ADDR_W-1:0] addr_q;
   logic [TID_W-1:0]  tid_q;
   logic              hit_v;

   assign hit_v       = ld_valid_i && hit_i;
   assign trap_fire_o = hit_v && !pending_q;
   assign replay_o    = hit_v && pending_q;
   assign wb_valid_o  = ld_valid_i && !hit_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         addr_q    <= '0;
         tid_q     <= '0;
      end else if (trap_fire_o) begin
         pending_q <= 1'b1;
         addr_q    <= ld_addr_i;
         tid_q     <= ld_tid_i;
      end else if (ack_i) begin
         pending_q <= 1'b0;
      end
   end

   assign pending_o   = pending_q;
   assign trap_addr_o = addr_q;
   assign trap_tid_o  = tid_q;
endmodule

// File: rtl/ld_sentinel_trap.sv
module ld_sentinel_trap #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 48,
   parameter int TID_W  = 3,
   parameter int NBYTES = DATA_W / 8,
   parameter int OFF_W  = $clog2(NBYTES),
   parameter int SIZE_W = $clog2(OFF_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic              cfg_wr_addr,
   input  logic [DATA_W-1:0] cfg_wr_data,
   input  logic              ld_valid,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [TID_W-1:0]  ld_tid,
   input  logic [SIZE_W-1:0] ld_size,
   output logic              wb_valid,
   output logic [DATA_W-1:0] wb_data,
   output logic [TID_W-1:0]  wb_tid,
   output logic              trap_fire,
   output logic              replay,
   output logic              trap_pending,
   output logic [ADDR_W-1:0] trap_addr,
   output logic [TID_W-1:0]  trap_tid,
   input  logic              trap_ack
);
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if ((1 << OFF_W) != NBYTES) begin : g_bad_pow2
      $error("DATA_W / 8 must be a power of two");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the lane offset");
   end
   if (TID_W < 1) begin : g_bad_tid
      $error("TID_W must be at least 1");
   end

   logic [DATA_W-1:0] cfg_sentinel;
   logic              cfg_en;
   logic [DATA_W-1:0] sent_aligned;
   logic [NBYTES-1:0] byte_mask;
   logic              data_match;
   logic              hit;

   ldsn_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr_en),
      .wr_addr    (cfg_wr_addr),
      .wr_data    (cfg_wr_data),
      .sentinel_o (cfg_sentinel),
      .enable_o   (cfg_en)
   );

   ldsn_lane_align #(.NBYTES(NBYTES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_align (
      .size_i         (ld_size),
      .addr_lo_i      (ld_addr[OFF_W-1:0]),
      .sentinel_i     (cfg_sentinel),
      .sent_aligned_o (sent_aligned),
      .byte_mask_o    (byte_mask)
   );

   ldsn_compare #(.NBYTES(NBYTES)) u_cmp (
      .data_i  (ld_data),
      .ref_i   (sent_aligned),
      .mask_i  (byte_mask),
      .match_o (data_match)
   );

   assign hit = cfg_en && data_match;

   ldsn_trap_ctl #(.ADDR_W(ADDR_W), .TID_W(TID_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_valid_i  (ld_valid),
      .ld_addr_i   (ld_addr),
      .ld_tid_i    (ld_tid),
      .hit_i       (hit),
      .ack_i       (trap_ack),
      .wb_valid_o  (wb_valid),
      .trap_fire_o (trap_fire),
      .replay_o    (replay),
      .pending_o   (trap_pending),
      .trap_addr_o (trap_addr),
      .trap_tid_o  (trap_tid)
   );

   assign wb_data = ld_data;
   assign wb_tid  = ld_tid;
endmodule

// File: rtl/ldsn_checker.sv
module ldsn_checker #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 48,
   parameter int TID_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic              ld_valid,
   input logic [DATA_W-1:0] ld_data,
   input logic [ADDR_W-1:0] ld_addr,
   input logic [TID_W-1:0]  ld_tid,
   input logic              wb_valid,
   input logic [DATA_W-1:0] wb_data,
   input logic              trap_fire,
   input logic              replay,
   input logic              trap_pending,
   input logic [ADDR_W-1:0] trap_addr,
   input logic [TID_W-1:0]  trap_tid,
   input logic              trap_ack
);
   a_r3_disabled_delivers: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && ld_valid) |-> (wb_valid && !trap_fire && !replay));

   a_r6_trap_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire |-> (!wb_valid && ld_valid && cfg_en));

   a_r7_wb_data_intact: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_data == ld_data && !trap_fire && !replay));

   a_r8_status_capture: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire |=> (trap_pending && trap_addr == $past(ld_addr) && trap_tid == $past(ld_tid)));

   a_r9_no_second_trap: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pending |-> !trap_fire);

   a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_pending && !trap_ack) |=> (trap_pending && $stable(trap_addr) && $stable(trap_tid)));

   a_r9_replay_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
      replay |-> (trap_pending && !wb_valid));

   a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_pending && trap_ack) |=> !trap_pending);

   a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wb_valid, trap_fire, replay}));
endmodule

bind ld_sentinel_trap ldsn_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TID_W(TID_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_en       (cfg_en),
   .ld_valid     (ld_valid),
   .ld_data      (ld_data),
   .ld_addr      (ld_addr),
   .ld_tid       (ld_tid),
   .wb_valid     (wb_valid),
   .wb_data      (wb_data),
   .trap_fire    (trap_fire),
   .replay       (replay),
   .trap_pending (trap_pending),
   .trap_addr    (trap_addr),
   .trap_tid     (trap_tid),
   .trap_ack     (trap_ack)
);

// File: tb/ld_sentinel_trap_tb_top.sv
`timescale 1ns/1ps
module ld_sentinel_trap_tb_top;
   localparam int DW = 64;
   localparam int AW = 48;
   localparam int TW = 3;
   localparam logic [DW-1:0] SENT_A = 64'hF0E1D2C3B4A59687;
   localparam logic [DW-1:0] SENT_B = 64'h1122334455667788;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic          cfg_wr_addr = 1'b0;
   logic [DW-1:0] cfg_wr_data = '0;
   logic          ld_valid = 1'b0;
   logic [DW-1:0] ld_data = '0;
   logic [AW-1:0] ld_addr = '0;
   logic [TW-1:0] ld_tid = '0;
   logic [1:0]    ld_size = 2'd3;
   logic          trap_ack = 1'b0;
   logic          wb_valid, trap_fire, replay, trap_pending;
   logic [DW-1:0] wb_data;
   logic [TW-1:0] wb_tid, trap_tid;
   logic [AW-1:0] trap_addr;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   always #2.5 clk = ~clk;

   ld_sentinel_trap dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
      .cfg_wr_data(cfg_wr_data), .ld_valid(ld_valid), .ld_data(ld_data),
      .ld_addr(ld_addr), .ld_tid(ld_tid), .ld_size(ld_size), .wb_valid(wb_valid),
      .wb_data(wb_data), .wb_tid(wb_tid), .trap_fire(trap_fire), .replay(replay),
      .trap_pending(trap_pending), .trap_addr(trap_addr), .trap_tid(trap_tid),
      .trap_ack(trap_ack)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one cycle of inputs at the falling edge; outputs are checked 1 ns later.
   task automatic step(bit v, logic [DW-1:0] d, logic [AW-1:0] a, logic [TW-1:0] t,
                       logic [1:0] s, bit ack, bit we, bit wa, logic [DW-1:0] wd);
      @(negedge clk);
      ld_valid = v; ld_data = d; ld_addr = a; ld_tid = t; ld_size = s;
      trap_ack = ack; cfg_wr_en = we; cfg_wr_addr = wa; cfg_wr_data = wd;
      #1;
   endtask

   task automatic idle(bit ack);
      step(1'b0, '0, '0, '0, 2'd3, ack, 1'b0, 1'b0, '0);
   endtask

   task automatic cfg(bit wa, logic [DW-1:0] wd);
      step(1'b0, '0, '0, '0, 2'd3, 1'b0, 1'b1, wa, wd);
   endtask

   function automatic bit exp_hit(logic [DW-1:0] d, logic [AW-1:0] a, int s, logic [DW-1:0] sent);
      int n   = 1 << s;
      int off = int'(a[2:0]) & ~(n - 1);
      for (int i = 0; i < n; i++)
         if (d[8*i +: 8] != sent[8*((off + i) % 8) +: 8]) return 1'b0;
      return 1'b1;
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state; zero data matches the zero sentinel but checking is off (R3)
      step(1'b1, '0, 48'h1000, 3'd1, 2'd3, 1'b0, 1'b0, 1'b0, '0);
      check("R1 pending", trap_pending, 0);
      check("R1 addr", trap_addr, 0);
      check("R1 tid", trap_tid, 0);
      check("R3 zero data delivered", wb_valid, 1);
      check("R3 no trap", trap_fire, 0);

      cfg(1'b0, SENT_A);
      step(1'b1, SENT_A, 48'h2000, 3'd2, 2'd3, 1'b0, 1'b0, 1'b0, '0);
      check("R3 disabled sentinel delivered", wb_valid, 1);
      check("R3 disabled no trap", trap_fire, 0);
      // R2: enable written in the same cycle as a matching load: old value applies
      step(1'b1, SENT_A, 48'h2008, 3'd2, 2'd3, 1'b0, 1'b1, 1'b1, 64'h1);
      check("R2 enable not yet active", wb_valid, 1);
      step(1'b1, SENT_A, 48'h2010, 3'd3, 2'd3, 1'b0, 1'b0, 1'b0, '0);
      check("R4 full match traps", trap_fire, 1);
      check("R6 no writeback", wb_valid, 0);
      idle(1'b1);
      check("R8 pending", trap_pending, 1);
      check("R8 addr", trap_addr, 48'h2010);
      check("R8 tid", trap_tid, 3);

      // R5 sweep: sizes x aligned offsets x corrupted byte position
      for (int s = 0; s < 4; s++) begin
         for (int off = 0; off < 8; off += (1 << s)) begin
            for (int j = -1; j < 8; j++) begin
               int n = 1 << s;
               logic [DW-1:0] d;
               logic [AW-1:0] a;
               logic [TW-1:0] t;
               bit h;
               for (int i = 0; i < 8; i++)
                  d[8*i +: 8] = (i < n) ? SENT_A[8*((off + i) % 8) +: 8] : 8'(8'h5A ^ i);
               if (j >= 0) d[8*j +: 8] = d[8*j +: 8] ^ 8'hFF;
               a = AW'(48'h7000_0000 + 64 * (s * 100 + off * 10 + j + 1)) |
                   AW'(off | ((j + 3) & (n - 1)));
               t = TW'(s + off + j + 1);
               h = exp_hit(d, a, s, SENT_A);
               step(1'b1, d, a, t, 2'(s), 1'b0, 1'b0, 1'b0, '0);
               check("R10 pending cleared", 64'(trap_pending), 0);
               check(h ? "R5 narrow match traps" : "R5 narrow mismatch passes", trap_fire, h);
               check("R7 writeback when no match", wb_valid, !h);
               if (!h) begin
                  check("R7 wb data", wb_data, d);
                  check("R7 wb tid", wb_tid, t);
               end else begin
                  idle(1'b1);
                  check("R8 sweep addr", trap_addr, a);
                  check("R8 sweep tid", trap_tid, t);
               end
            end
         end
      end

      // R9: pending trap blocks a second one
      step(1'b1, SENT_A, 48'hA000, 3'd4, 2'd3, 1'b0, 1'b0, 1'b0, '0);
      check("R6 trap", trap_fire, 1);
      step(1'b1, SENT_A, 48'hB000, 3'd5, 2'd3, 1'b0, 1'b0, 1'b0, '0);
      check("R9 no second trap", trap_fire, 0);
      check("R9 replay", replay, 1);
      check("R9 not delivered", wb_valid, 0);
      step(1'b1, 64'h0, 48'hC000, 3'd6, 2'd3, 1'b0, 1'b0, 1'b0, '0);
      check("R9 mismatch delivered", wb_valid, 1);
      check("R9 addr held", trap_addr, 48'hA000);
      check("R9 tid held", trap_tid, 4);
      // R10: ack together with a match still replays; pending clears afterwards
      step(1'b1, SENT_A, 48'hD000, 3'd7, 2'd3, 1'b1, 1'b0, 1'b0, '0);
      check("R10 replay during ack", replay, 1);
      idle(1'b0);
      check("R10 cleared", trap_pending, 0);
      check("R10 addr kept", trap_addr, 48'hA000);
      step(1'b1, SENT_A, 48'hE000, 3'd2, 2'd3, 1'b0, 1'b0, 1'b0, '0);
      check("R10 traps again", trap_fire, 1);
      idle(1'b1);
      check("R10 new addr", trap_addr, 48'hE000);

      // R2: new sentinel written together with a load carrying it
      step(1'b1, SENT_B, 48'hF000, 3'd1, 2'd3, 1'b0, 1'b1, 1'b0, SENT_B);
      check("R2 old sentinel still used", trap_fire, 0);
      step(1'b1, SENT_B, 48'hF008, 3'd1, 2'd3, 1'b0, 1'b0, 1'b0, '0);
      check("R2 new sentinel used", trap_fire, 1);
      idle(1'b1);
      // R3: disable
      cfg(1'b1, 64'h0);
      step(1'b1, SENT_B, 48'hF010, 3'd0, 2'd3, 1'b0, 1'b0, 1'b0, '0);
      check("R3 disabled again", wb_valid, 1);
      check("R3 no trap after disable", trap_fire, 0);
      idle(1'b0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule